// File: doc/BRIEF.md
# Pixel Row Zero-Suppression Encoder

This block turns one row of binary pixel hits into a short list of hit clusters. A row of 512 hit bits is divided into 8 banks of 64 columns, and every bank is searched in the same cycle for groups of adjacent hits. A group of up to 4 neighbouring hits becomes one cluster. Longer groups are cut into consecutive clusters of at most 4 pixels. Each bank keeps a limited number of clusters. The banks are then merged, from the lowest column upward, into a capped list for the whole row, and any loss of hits raises an overflow mark.

Each row that has clusters is written as 16-bit words through a memory write port. A header word comes first, and one word per cluster follows it. Two memories take turns. One collects the current frame while the other is read out. A frame-swap pulse closes the frame with a trailer word and exchanges the roles of the two memories. The row period sets the timing: a new row is only accepted once the previous row's words and any pending trailer have been written.

Top module: `pzs_encoder`

## Requirements
- R1: Clusters are found separately inside each 64-column bank, scanning upward from the bank's lowest column. A run of adjacent hits starts a cluster, and a cluster holds at most 4 pixels. The 5th pixel of a run starts a new cluster. A run that crosses a bank edge is split at that edge.
- R2: A cluster word has bit 15 = 0, bits 14:6 = first column (0 to 511), bits 5:4 = length minus 1, and bits 3:0 = 0.
- R3: A bank keeps only its 6 lowest clusters. Further clusters in that bank are dropped, and the row's overflow bit is set.
- R4: The row list holds at most 12 clusters, in ascending column order. Clusters beyond the 12th are dropped, and the overflow bit is set.
- R5: A header word has bit 15 = 1, bits 14:5 = row address, bit 4 = overflow, and bits 3:0 = number of cluster words that follow (1 to 12).
- R6: A row with no hits writes no words.
- R7: A row is accepted on the clock edge where row_valid is high and the block is idle. The header is written on that edge. Cluster words are written on the following edges, one per edge. Word addresses within a frame rise by one from 0.
- R8: row_valid is ignored while the cluster words of an earlier row or a pending trailer are still to be written.
- R9: A frame_swap pulse writes a trailer word into the memory being filled, at the next address. The trailer has bit 15 = 1, bits 14:4 = number of words in the frame before it, and bits 3:0 = 0. On the same edge the memories swap roles: rd_sel flips, and the next frame starts at address 0 in the other memory.
- R10: If frame_swap arrives while words are still to be written, or together with an accepted row, that row stays in the outgoing frame. The trailer follows its last word.
- R11: After reset no write is issued, memory 0 is the one being filled, and rd_sel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_valid | input | 1 | Row hit vector and address are presented |
| row_addr | input | 10 | Row address copied into the header |
| row_hits | input | 512 | One bit per column, 1 = hit |
| frame_swap | input | 1 | Pulse that closes the frame and swaps the memories |
| wr_en | output | 1 | Memory write strobe |
| wr_sel | output | 1 | Memory that receives the write |
| wr_addr | output | 11 | Word address within the frame |
| wr_data | output | 16 | Header, cluster or trailer word |
| rd_sel | output | 1 | Memory currently free for readout |

## Verification
Two functions can fall in the same cycle, and the bench provokes both on purpose. In the first case, a row and a frame_swap pulse are driven on the same edge. The expected stream places the row's header and clusters in the outgoing memory, followed by a trailer that counts them. In the second case, a further row_valid pulse is driven while cluster words are still being written. The bench expects no words from that pulse. Any extra write, or any misplaced address or memory select, appears as a mismatch against the stream the bench predicts.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
  localparam int WORD_W = 16;
  localparam int COL_W  = 9;
  localparam int RA_W   = 10;
  localparam int CNT_W  = 4;
  localparam int WC_W   = WORD_W - 1 - CNT_W;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [1:0]       lm1;
  } clus_t;

  function automatic logic [WORD_W-1:0] mk_clus(clus_t c);
    return {1'b0, c.col, c.lm1, 4'b0000};
  endfunction

  function automatic logic [WORD_W-1:0] mk_head(logic [RA_W-1:0] ra, logic ov,
                                                logic [CNT_W-1:0] n);
    return {1'b1, ra, ov, n};
  endfunction

  function automatic logic [WORD_W-1:0] mk_trail(logic [WC_W-1:0] wc);
    return {1'b1, wc, 4'b0000};
  endfunction
endpackage

// File: rtl/pzs_bank_search.sv
module pzs_bank_search
  import pzs_pkg::*;
#(
  parameter int W       = 64,
  parameter int CAP     = 6,
  parameter int RUN_MAX = 4,
  parameter int BASE    = 0,
  localparam int SIW    = $clog2(CAP),
  localparam int BCW    = $clog2(CAP + 1)
) (
  input  logic [W-1:0]   hits,
  output clus_t          slots [CAP],
  output logic [BCW-1:0] cnt,
  output logic           ovf
);
  always_comb begin
    int  run;
    int  n;
    logic kept;
    for (int k = 0; k < CAP; k++) slots[k] = '0;
    ovf  = 1'b0;
    run  = 0;
    n    = 0;
    kept = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!hits[i]) begin
        run = 0;
      end else if (run == 0 || run == RUN_MAX) begin
        run = 1;
        if (n < CAP) begin
          slots[SIW'(n)].col = COL_W'(BASE + i);
          slots[SIW'(n)].lm1 = 2'd0;
          n    = n + 1;
          kept = 1'b1;
        end else begin
          ovf  = 1'b1;
          kept = 1'b0;
        end
      end else begin
        run = run + 1;
        if (kept) slots[SIW'(n - 1)].lm1 = slots[SIW'(n - 1)].lm1 + 2'd1;
      end
    end
    cnt = BCW'(n);
  end
endmodule

// File: rtl/pzs_row_merge.sv
module pzs_row_merge
  import pzs_pkg::*;
#(
  parameter int NBANK    = 8,
  parameter int BANK_CAP = 6,
  parameter int ROW_CAP  = 12,
  localparam int BCW     = $clog2(BANK_CAP + 1),
  localparam int RIW     = $clog2(ROW_CAP)
) (
  input  clus_t            bslot [NBANK][BANK_CAP],
  input  logic [BCW-1:0]   bcnt  [NBANK],
  input  logic [NBANK-1:0] bovf,
  output clus_t            list  [ROW_CAP],
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  always_comb begin
    int n;
    for (int k = 0; k < ROW_CAP; k++) list[k] = '0;
    n   = 0;
    ovf = |bovf;
    for (int b = 0; b < NBANK; b++) begin
      for (int s = 0; s < BANK_CAP; s++) begin
        if (s < int'(bcnt[b])) begin
          if (n < ROW_CAP) begin
            list[RIW'(n)] = bslot[b][s];
            n = n + 1;
          end else begin
            ovf = 1'b1;
          end
        end
      end
    end
    cnt = CNT_W'(n);
  end
endmodule

// File: rtl/pzs_frame_writer.sv
module pzs_frame_writer
  import pzs_pkg::*;
#(
  parameter int ROW_CAP = 12,
  localparam int PTR_W  = $clog2(ROW_CAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_valid,
  input  logic [RA_W-1:0]   row_addr,
  input  logic              frame_swap,
  input  clus_t             list [ROW_CAP],
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [WC_W-1:0]   wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_sel,
  output logic              busy,
  output logic              row_take,
  output logic              trailer_go
);
  logic [CNT_W-1:0] rem;
  logic [PTR_W-1:0] ptr;
  clus_t            lst [ROW_CAP];
  logic             pend;
  logic             fill;
  logic [WC_W-1:0]  wcnt;

  assign busy       = (rem != '0) || pend;
  assign row_take   = row_valid && !busy;
  assign trailer_go = (rem == '0) && !row_take && (pend || frame_swap);
  assign rd_sel     = ~fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      ptr     <= '0;
      pend    <= 1'b0;
      fill    <= 1'b0;
      wcnt    <= '0;
      wr_en   <= 1'b0;
      wr_sel  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int k = 0; k < ROW_CAP; k++) lst[k] <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rem != '0) begin
        wr_en   <= 1'b1;
        wr_sel  <= fill;
        wr_addr <= wcnt;
        wr_data <= mk_clus(lst[ptr]);
        wcnt    <= wcnt + 1'b1;
        ptr     <= ptr + 1'b1;
        rem     <= rem - 1'b1;
        if (frame_swap) pend <= 1'b1;
      end else if (row_take) begin
        lst <= list;
        ptr <= '0;
        rem <= cnt;
        if (frame_swap) pend <= 1'b1;
        if (cnt != '0) begin
          wr_en   <= 1'b1;
          wr_sel  <= fill;
          wr_addr <= wcnt;
          wr_data <= mk_head(row_addr, ovf, cnt);
          wcnt    <= wcnt + 1'b1;
        end
      end else if (trailer_go) begin
        wr_en   <= 1'b1;
        wr_sel  <= fill;
        wr_addr <= wcnt;
        wr_data <= mk_trail(wcnt);
        fill    <= ~fill;
        wcnt    <= '0;
        pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pzs_encoder.sv
module pzs_encoder
  import pzs_pkg::*;
#(
  parameter int NCOL     = 512,
  parameter int NBANK    = 8,
  parameter int RUN_MAX  = 4,
  parameter int BANK_CAP = 6,
  parameter int ROW_CAP  = 12,
  localparam int BANK_W  = NCOL / NBANK,
  localparam int BCW     = $clog2(BANK_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_valid,
  input  logic [RA_W-1:0]   row_addr,
  input  logic [NCOL-1:0]   row_hits,
  input  logic              frame_swap,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [WC_W-1:0]   wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_sel
);
  clus_t            bslot [NBANK][BANK_CAP];
  logic [BCW-1:0]   bcnt  [NBANK];
  logic [NBANK-1:0] bovf;
  clus_t            list  [ROW_CAP];
  logic [CNT_W-1:0] row_cnt;
  logic             row_ovf;
  logic             busy;
  logic             row_take;
  logic             trailer_go;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pzs_bank_search #(
      .W(BANK_W), .CAP(BANK_CAP), .RUN_MAX(RUN_MAX), .BASE(b * BANK_W)
    ) u_search (
      .hits (row_hits[b*BANK_W +: BANK_W]),
      .slots(bslot[b]),
      .cnt  (bcnt[b]),
      .ovf  (bovf[b])
    );
  end

  pzs_row_merge #(
    .NBANK(NBANK), .BANK_CAP(BANK_CAP), .ROW_CAP(ROW_CAP)
  ) u_merge (
    .bslot(bslot), .bcnt(bcnt), .bovf(bovf),
    .list(list), .cnt(row_cnt), .ovf(row_ovf)
  );

  pzs_frame_writer #(.ROW_CAP(ROW_CAP)) u_writer (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_addr(row_addr),
    .frame_swap(frame_swap), .list(list), .cnt(row_cnt), .ovf(row_ovf),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .busy(busy), .row_take(row_take), .trailer_go(trailer_go)
  );
endmodule

// File: rtl/pzs_encoder_chk.sv
module pzs_encoder_chk
  import pzs_pkg::*;
#(
  parameter int NCOL    = 512,
  parameter int ROW_CAP = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_valid,
  input logic [NCOL-1:0]   row_hits,
  input logic              busy,
  input logic              row_take,
  input logic              trailer_go,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [WC_W-1:0]   wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_sel
);
  a_r7_clus_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[15] |-> $past(wr_en));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) && (wr_sel == $past(wr_sel)) |-> wr_addr == $past(wr_addr) + 1'b1);

  a_r4_col_order: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[15] && $past(wr_en) && !$past(wr_data[15])
      |-> wr_data[14:6] > $past(wr_data[14:6]));

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15] |-> wr_data[3:0] <= CNT_W'(ROW_CAP));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[15] |-> wr_data[3:0] == 4'd0);

  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && busy |=> !(wr_en && wr_data[15] && wr_data[3:0] != 4'd0));

  a_r6_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    row_take && !(|row_hits) && !trailer_go |=> !wr_en);

  a_r9_swap_flip: assert property (@(posedge clk) disable iff (!rst_n)
    trailer_go |=> wr_en && wr_data[15] && (wr_data[3:0] == 4'd0) && (rd_sel != $past(rd_sel)));
endmodule

bind pzs_encoder pzs_encoder_chk #(.NCOL(NCOL), .ROW_CAP(ROW_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_hits(row_hits),
  .busy(busy), .row_take(row_take), .trailer_go(trailer_go),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_sel(rd_sel)
);

// File: tb/pzs_encoder_tb.sv
module pzs_encoder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         row_valid = 1'b0;
  logic [9:0]   row_addr = '0;
  logic [511:0] row_hits = '0;
  logic         frame_swap = 1'b0;
  logic         wr_en;
  logic         wr_sel;
  logic [10:0]  wr_addr;
  logic [15:0]  wr_data;
  logic         rd_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_sel = 1'b0;
  int exp_cnt = 0;
  logic [27:0] q_w[$];
  string       q_r[$];
  logic [27:0] e_w;
  string       e_r;

  always #10 clk = ~clk;

  pzs_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_addr(row_addr),
    .row_hits(row_hits), .frame_swap(frame_swap), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel)
  );

  function automatic void push(bit s, logic [15:0] d, string r);
    q_w.push_back({s, 11'(exp_cnt), d});
    q_r.push_back(r);
    exp_cnt++;
  endfunction

  // Reference: walk each bank run by run, then cap banks and the row.
  function automatic void ref_row(logic [511:0] h, logic [9:0] ra, string r);
    int cols[$];
    int lens[$];
    bit ov;
    int c;
    int len;
    int kept;
    ov = 0;
    for (int b = 0; b < 8; b++) begin
      kept = 0;
      c = b * 64;
      while (c < b * 64 + 64) begin
        if (h[c]) begin
          len = 0;
          while (len < 4 && c + len < b * 64 + 64 && h[c + len]) len++;
          if (kept < 6) begin
            cols.push_back(c); lens.push_back(len); kept++;
          end else ov = 1;
          c += len;
        end else c++;
      end
    end
    if (cols.size() > 12) begin
      ov = 1;
      while (cols.size() > 12) begin void'(cols.pop_back()); void'(lens.pop_back()); end
    end
    if (cols.size() == 0) return;
    push(exp_sel, {1'b1, ra, ov, 4'(cols.size())}, r);
    foreach (cols[i]) push(exp_sel, {1'b0, 9'(cols[i]), 2'(lens[i] - 1), 4'b0}, r);
  endfunction

  function automatic void ref_swap();
    push(exp_sel, {1'b1, 11'(exp_cnt), 4'b0}, "R9");
    exp_sel = ~exp_sel;
    exp_cnt = 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      n_chk++;
      if (q_w.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected write: actual %h sel %0d addr %0d, expected none",
                 wr_data, wr_sel, wr_addr);
      end else begin
        e_w = q_w.pop_front();
        e_r = q_r.pop_front();
        if ({wr_sel, wr_addr, wr_data} !== e_w) begin
          n_bad++;
          $display("FAIL %s write: actual sel %0d addr %0d data %h, expected sel %0d addr %0d data %h",
                   e_r, wr_sel, wr_addr, wr_data, e_w[27], e_w[26:16], e_w[15:0]);
        end
      end
    end
  end

  task automatic check(bit ok, string r, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d, expected %0d", r, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_row(logic [511:0] h, logic [9:0] ra, string r);
    @(negedge clk);
    row_valid = 1'b1; row_hits = h; row_addr = ra;
    ref_row(h, ra, r);
    @(negedge clk);
    row_valid = 1'b0;
    idle(15);
  endtask

  task automatic do_swap();
    @(negedge clk);
    frame_swap = 1'b1;
    ref_swap();
    @(negedge clk);
    frame_swap = 1'b0;
    idle(3);
    check(rd_sel == ~exp_sel, "R9 rd_sel", int'(rd_sel), int'(~exp_sel));
  endtask

  function automatic logic [511:0] rnd_row();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) begin
      case ($urandom % 4)
        0: v[k*32 +: 32] = '0;
        1: v[k*32 +: 32] = $urandom & $urandom & $urandom;
        2: v[k*32 +: 32] = $urandom | $urandom;
        default: v[k*32 +: 32] = $urandom;
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] h;
    void'($urandom(32'd2718));
    idle(3);
    // R11 reset state
    check(wr_en == 1'b0, "R11 wr_en", int'(wr_en), 0);
    check(rd_sel == 1'b1, "R11 rd_sel", int'(rd_sel), 1);
    rst_n = 1'b1;
    idle(2);

    // R1 R2: single hit, run of 4, run of 5 split 4+1
    h = '0; h[0] = 1; h[13:10] = '1; h[24:20] = '1;
    send_row(h, 10'd5, "R1");
    // R1: run crossing bank edge 62..65
    h = '0; h[65:62] = '1;
    send_row(h, 10'd6, "R1");
    // R2 R5: last column and top row address
    h = '0; h[511] = 1;
    send_row(h, 10'd1023, "R2");
    // R3: 8 isolated hits in bank 2, one hit in bank 3
    h = '0;
    for (int k = 0; k < 8; k++) h[128 + 2*k] = 1;
    h[200] = 1;
    send_row(h, 10'd7, "R3");
    // R4: one hit every 16 columns -> 32 clusters
    h = '0;
    for (int k = 0; k < 32; k++) h[16*k] = 1;
    send_row(h, 10'd8, "R4");
    // R3 R4 R5: full row
    send_row('1, 10'd9, "R5");
    // R6: empty row writes nothing
    send_row('0, 10'd10, "R6");
    // R9: swap while idle, then a row starts at address 0
    do_swap();
    h = '0; h[300] = 1;
    send_row(h, 10'd11, "R9");

    // R8: second row during cluster writes is ignored
    h = '0; h[7:0] = 8'b01010101;
    @(negedge clk);
    row_valid = 1'b1; row_hits = h; row_addr = 10'd12;
    ref_row(h, 10'd12, "R8");
    @(negedge clk);
    row_hits = '1; row_addr = 10'd13;
    @(negedge clk);
    row_valid = 1'b0;
    idle(15);

    // R10: row and swap on the same edge
    h = '0; h[40] = 1; h[100] = 1; h[450] = 1;
    @(negedge clk);
    row_valid = 1'b1; row_hits = h; row_addr = 10'd14; frame_swap = 1'b1;
    ref_row(h, 10'd14, "R10");
    ref_swap();
    @(negedge clk);
    row_valid = 1'b0; frame_swap = 1'b0;
    idle(15);
    check(rd_sel == ~exp_sel, "R10 rd_sel", int'(rd_sel), int'(~exp_sel));

    // R10: swap arriving during cluster writes
    h = '0; h[3] = 1; h[70] = 1; h[140] = 1; h[210] = 1;
    @(negedge clk);
    row_valid = 1'b1; row_hits = h; row_addr = 10'd15;
    ref_row(h, 10'd15, "R10");
    ref_swap();
    @(negedge clk);
    row_valid = 1'b0; frame_swap = 1'b1;
    @(negedge clk);
    frame_swap = 1'b0;
    idle(15);

    // Random rows with periodic swaps (R1 R3 R4 R7)
    for (int r = 0; r < 60; r++) begin
      send_row(rnd_row(), 10'($urandom), "R7");
      if (r % 9 == 8) do_swap();
    end
    do_swap();

    idle(5);
    check(q_w.size() == 0, "R7 pending expected words", q_w.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule